// File: doc/BRIEF.md
# Transport-Stream Capture Interrupt Controller

This block keeps count of transport-stream packets that a capture engine writes into a fixed buffer of eight 188-byte packets (1504 bytes), and turns that progress into interrupts for the host. Each packet landing in the buffer is reported by a one-cycle `pkt_wr` strobe. The `buf_full` input tells the block that the buffer has no room. A packet strobe that arrives while the buffer is full is not counted. It is flagged as an overflow instead.

All control and status sit in one 32-bit word on a simple register port. A write applies in the clock edge it is presented. A read is combinational and needs no strobe. The word holds the packet count since the last acknowledge, a threshold for the buffer-done event, a mask for each event source, a write-one acknowledge, and an active-low run bit. Clearing the run bit holds the capture state in reset. The `irq` output is a level. It is the OR of the unmasked buffer-done and overflow flags.

There is no data stream through the block. Only strobes and levels cross its edge, so none of its pins carries a valid/ready handshake or back-pressure.

Top module: `ts_cap_irq_ctrl`

## Requirements
- R1: After `rst`, the register reads 0x00027000 while `near_full` and `lock` are low. The four mask bits (17, 14, 13, 12) are set. The run bit 15, the threshold, the count and both flags are zero, and `irq` is low.
- R2: Bits 31:24 hold the packet count. The count goes up by one for each `pkt_wr` seen while bit 15 is 1 and `buf_full` is 0. It saturates at 255.
- R3: Bits 6:0 hold the threshold. When a counted packet brings the count to a value at or above a nonzero threshold, the buffer-done flag (bit 16) sets. It then stays set until acknowledged. A threshold of zero never sets it.
- R4: A `pkt_wr` while `buf_full` is 1 and bit 15 is 1 sets the overflow flag (bit 11) and leaves the count unchanged.
- R5: A write with bit 8 set clears the count and both flags in the same edge. A packet counted in that same cycle leaves the count at 1. Bit 8 always reads 0.
- R6: `irq` is high exactly while (bit 16 and not bit 17) or (bit 11 and not bit 14). A mask hides the flag from `irq` but not from the register.
- R7: While bit 15 is 0, the count and both flags are held at zero and `pkt_wr` is ignored. A write that clears bit 15 zeroes them in that same edge.
- R8: Bits 10 and 9 show the live `near_full` and `lock` inputs. Mask bits 13 and 12 are stored and read back, and have no effect on `irq`.
- R9: A write leaves unchanged the fields that are status only: the count, bit 16, bit 11, bits 10 and 9, bits 23:18 and bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Write strobe for the control/status word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current control/status word |
| pkt_wr | input | 1 | One packet was written into the buffer |
| buf_full | input | 1 | Capture buffer has no free slot |
| near_full | input | 1 | Buffer almost-full level |
| lock | input | 1 | Demodulator lock level |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest state to reach from the ports is a count held at saturation. Getting there takes more than 255 back-to-back packet strobes with no acknowledge in between. The stimulus sends 300 consecutive strobes and then checks that the count sits at 255 and the done flag is still set. A second hard case is an acknowledge that lands in the same edge as a new packet. The vector table drives both strobes together and expects a count of one. A third is a write that drops the run bit: the bench checks the capture state is cleared in that edge and then stays deaf to further packets.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = 8;
  localparam int THR_W    = 7;
  localparam int B_DMASK  = 17;
  localparam int B_DONE   = 16;
  localparam int B_RUN    = 15;
  localparam int B_OMASK  = 14;
  localparam int B_NMASK  = 13;
  localparam int B_LMASK  = 12;
  localparam int B_OVF    = 11;
  localparam int B_NEAR   = 10;
  localparam int B_LOCK   = 9;
  localparam int B_ACK    = 8;

  typedef struct packed {
    logic             done_mask;
    logic             run;
    logic             ovf_mask;
    logic             near_mask;
    logic             lock_mask;
    logic [THR_W-1:0] thr;
  } cap_ctrl_t;
endpackage

// File: rtl/ts_cap_ctrl.sv
module ts_cap_ctrl
  import ts_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [WORD_W-1:0] wdata,
  output cap_ctrl_t         ctrl_q,
  output logic              run_nxt,
  output logic              ack
);
  cap_ctrl_t ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (we) begin
      ctrl_d.done_mask = wdata[B_DMASK];
      ctrl_d.run       = wdata[B_RUN];
      ctrl_d.ovf_mask  = wdata[B_OMASK];
      ctrl_d.near_mask = wdata[B_NMASK];
      ctrl_d.lock_mask = wdata[B_LMASK];
      ctrl_d.thr       = wdata[THR_W-1:0];
    end
  end

  assign run_nxt = ctrl_d.run;
  assign ack     = we & wdata[B_ACK];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '{done_mask: 1'b1, run: 1'b0, ovf_mask: 1'b1,
                 near_mask: 1'b1, lock_mask: 1'b1, thr: '0};
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  // R7: a written run value is what the register holds afterwards
  a_r7_run_follows_write: assert property (@(posedge clk) disable iff (rst)
    we |=> (ctrl_q.run == $past(wdata[B_RUN])));
endmodule

// File: rtl/ts_cap_counter.sv
module ts_cap_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] base;

  always_comb begin
    base = clr ? '0 : cnt_q;
    if (!run)            cnt_nxt = '0;
    else if (!inc)       cnt_nxt = base;
    else if (base == CMAX) cnt_nxt = CMAX;
    else                 cnt_nxt = base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  a_r2_saturate: assert property (@(posedge clk) disable iff (rst)
    (run && !clr && cnt_q == CMAX) |=> (cnt_q == CMAX));
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q <= 1));
endmodule

// File: rtl/ts_cap_flags.sv
module ts_cap_flags #(
  parameter int CW = 8,
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          clr,
  input  logic          inc,
  input  logic          drop,
  input  logic [CW-1:0] cnt_nxt,
  input  logic [TW-1:0] thr,
  output logic          done_q,
  output logic          ovf_q
);
  logic hit;

  assign hit = inc && (thr != '0) && (cnt_nxt >= CW'(thr));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      done_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      done_q <= (done_q & ~clr) | hit;
      ovf_q  <= (ovf_q & ~clr) | drop;
    end
  end

  a_r4_overflow_sets: assert property (@(posedge clk) disable iff (rst)
    (run && drop) |=> ovf_q);
  a_r3_done_sticky: assert property (@(posedge clk) disable iff (rst)
    (run && done_q && !clr) |=> done_q);
endmodule

// File: rtl/ts_cap_irq_ctrl.sv
module ts_cap_irq_ctrl
  import ts_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              pkt_wr,
  input  logic              buf_full,
  input  logic              near_full,
  input  logic              lock,
  output logic              irq
);
  localparam int PAD_W = WORD_W - CNT_W - 11 - THR_W;

  cap_ctrl_t        ctrl_q;
  logic             run_nxt, ack, inc, drop, done_q, ovf_q;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign inc  = pkt_wr & ~buf_full;
  assign drop = pkt_wr &  buf_full;

  ts_cap_ctrl u_ctrl (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .ctrl_q(ctrl_q), .run_nxt(run_nxt), .ack(ack)
  );

  ts_cap_counter #(.CW(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(run_nxt), .clr(ack), .inc(inc),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  ts_cap_flags #(.CW(CNT_W), .TW(THR_W)) u_flags (
    .clk(clk), .rst(rst), .run(run_nxt), .clr(ack), .inc(inc),
    .drop(drop), .cnt_nxt(cnt_nxt), .thr(ctrl_q.thr),
    .done_q(done_q), .ovf_q(ovf_q)
  );

  assign reg_rdata = {cnt_q, {PAD_W{1'b0}},
                      ctrl_q.done_mask, done_q, ctrl_q.run, ctrl_q.ovf_mask,
                      ctrl_q.near_mask, ctrl_q.lock_mask, ovf_q, near_full, lock,
                      1'b0, 1'b0, ctrl_q.thr};

  assign irq = (done_q & ~ctrl_q.done_mask) | (ovf_q & ~ctrl_q.ovf_mask);

  // R7: stopped capture holds count and flags at zero
  a_r7_stopped_idle: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.run |-> (cnt_q == '0 && !done_q && !ovf_q));
  // R6: a new request only follows a packet event or a register write
  a_r6_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(pkt_wr) || $past(reg_we)));
  // R5: after an acknowledge without a packet, no request remains
  a_r5_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (ack && !pkt_wr) |=> !irq);
endmodule

// File: tb/sim_ts_cap_irq_ctrl.sv
module sim_ts_cap_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pkt_wr = 1'b0, buf_full = 1'b0, near_full = 1'b0, lock = 1'b0;
  logic        irq;
  int          n_chk = 0, n_fail = 0, cycles = 0;

  always #2 clk = ~clk;

  ts_cap_irq_ctrl u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pkt_wr(pkt_wr), .buf_full(buf_full),
    .near_full(near_full), .lock(lock), .irq(irq)
  );

  // {we, wdata, pkt, full, near, lock, exp_rdata, exp_irq}
  localparam int NV = 16;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, 32'h0000_0000, 4'b0000, 32'h0002_7000, 1'b0}, // R1 idle
    {1'b1, 32'h0000_B004, 4'b0000, 32'h0000_B004, 1'b0}, // R7 run, thr 4
    {1'b0, 32'h0000_0000, 4'b1000, 32'h0100_B004, 1'b0}, // R2
    {1'b0, 32'h0000_0000, 4'b1000, 32'h0200_B004, 1'b0}, // R2
    {1'b0, 32'h0000_0000, 4'b1010, 32'h0300_B404, 1'b0}, // R8 near_full
    {1'b0, 32'h0000_0000, 4'b1000, 32'h0401_B004, 1'b1}, // R3 done
    {1'b0, 32'h0000_0000, 4'b0001, 32'h0401_B204, 1'b1}, // R8 lock, R6 level
    {1'b1, 32'h0000_B104, 4'b0000, 32'h0000_B004, 1'b0}, // R5 ack
    {1'b0, 32'h0000_0000, 4'b1100, 32'h0000_B804, 1'b1}, // R4 overflow
    {1'b1, 32'h0002_F004, 4'b0000, 32'h0002_F804, 1'b0}, // R6 masked
    {1'b1, 32'h0002_F104, 4'b1000, 32'h0102_F004, 1'b0}, // R5 ack + pkt
    {1'b1, 32'h0000_B004, 4'b0000, 32'h0100_B004, 1'b0}, // R6 unmask
    {1'b1, 32'hFF01_B804, 4'b0000, 32'h0100_B004, 1'b0}, // R9 ro ignored
    {1'b1, 32'h0000_3004, 4'b0000, 32'h0000_3004, 1'b0}, // R7 stop
    {1'b0, 32'h0000_0000, 4'b1000, 32'h0000_3004, 1'b0}, // R7 ignored
    {1'b1, 32'h0000_B004, 4'b0000, 32'h0000_B004, 1'b0}  // R7 restart
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [31:0] wd, input logic [3:0] ev);
    reg_we = we; reg_wdata = wd;
    {pkt_wr, buf_full, near_full, lock} = ev;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][69], VEC[i][68:37], VEC[i][36:33]);
      check($sformatf("R1-vector %0d rdata", i), reg_rdata, VEC[i][32:1]);
      check($sformatf("R6 vector %0d irq", i), {31'b0, irq}, {31'b0, VEC[i][0]});
    end
    // R2 saturation and R3 stickiness across 300 packets
    for (int k = 0; k < 300; k++) drive(1'b0, 32'h0, 4'b1000);
    drive(1'b0, 32'h0, 4'b0000);
    check("R2 saturated count", {24'b0, reg_rdata[31:24]}, 32'd255);
    check("R3 done held", {31'b0, reg_rdata[16]}, 32'd1);
    drive(1'b1, 32'h0000_B104, 4'b0000);
    check("R5 ack from saturation", reg_rdata, 32'h0000_B004);
    // R3 zero threshold never sets done
    drive(1'b1, 32'h0000_8000, 4'b1000);
    check("R3 zero threshold", reg_rdata, 32'h0100_8000);
    check("R3 zero threshold irq", {31'b0, irq}, 32'd0);
    // R8 near-full / lock unmasked still no irq
    drive(1'b0, 32'h0, 4'b0011);
    check("R8 live bits", reg_rdata, 32'h0100_8600);
    check("R8 no irq from near/lock", {31'b0, irq}, 32'd0);
    // R1 reset again
    rst = 1'b1;
    drive(1'b0, 32'h0, 4'b0000);
    rst = 1'b0;
    drive(1'b0, 32'h0, 4'b0000);
    check("R1 reset value", reg_rdata, 32'h0002_7000);
    check("R1 reset irq", {31'b0, irq}, 32'd0);
    finish_run();
  end
endmodule